// File: doc/BRIEF.md
# Consecutive-Count Digital Lock Detector

This block decides whether a phase-locked loop has settled, using one phase-error result per phase-detector comparison. Each comparison arrives as a one-cycle strobe that carries an unsigned error magnitude in fast-clock ticks. The block compares that magnitude against a programmable threshold. While unlocked, it waits for an unbroken run of small errors before it reports lock. While locked, it needs an unbroken run of large errors before it reports loss of lock. A two-bit select sets the run length. Any sample that goes the other way restarts the run.

A pulse from the register interface marks each new frequency setting. That pulse forces the detector back to the unlocked state at once. A mode input can bypass the decision: the raw phase-detector activity signal is then passed to the lock output, and the digital decision keeps running in the background.

Top module: `run_lock_detector`

## Requirements
- R1: After reset the detector is unlocked with its run counter at zero, and in digital mode (mode input 0) `lock_o` is low.
- R2: The run select sets a limit N: 2'b00 gives 7, 2'b01 gives 15, 2'b10 gives 31 and 2'b11 gives 63. Starting from unlocked with the counter at zero, lock is declared on the (N+1)th consecutive strobe whose error is strictly below the threshold. `lock_o` goes high after the clock edge that samples that strobe.
- R3: While unlocked, a strobe whose error is equal to or above the threshold clears the run, so N+1 further small-error strobes are needed.
- R4: While locked, unlock is declared on the (N+1)th consecutive strobe whose error is strictly above the threshold.
- R5: While locked, a strobe whose error is equal to or below the threshold clears the run of large errors.
- R6: A frequency-change pulse forces the unlocked state and clears the counter. It takes priority over a strobe in the same cycle, and that strobe is not counted.
- R7: Cycles without a strobe change neither the state nor the counter, whatever the error and threshold inputs carry.
- R8: With the mode input at 1, `lock_o` follows the raw phase-detector input combinationally. The digital decision keeps updating meanwhile and reappears on `lock_o` when the mode input returns to 0.
- R9: The counter is cleared on every change of state, so each new decision needs a full fresh run.
- R10: The counter never passes 63. If the select is lowered while a run is longer than the new limit, the next qualifying strobe completes the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | One-cycle strobe per phase comparison |
| phase_err_i | input | ERR_W | Unsigned phase-error magnitude in ticks |
| thresh_i | input | ERR_W | Error threshold in ticks |
| run_sel_i | input | 2 | Run length select |
| raw_mode_i | input | 1 | 1 passes raw detector activity to the output |
| pfd_raw_i | input | 1 | Raw phase-detector activity |
| freq_set_i | input | 1 | Frequency-change pulse |
| lock_o | output | 1 | Lock-detect output |

## Verification
The assertions assume that the error and threshold inputs only matter in a cycle with the strobe, and that the frequency-change pulse may arrive in any cycle, including one that carries a strobe. The stimulus raises each strobe for exactly one clock. It holds the threshold fixed while it moves the error between values below, equal to and above the threshold. It changes the select only between strobes, including once in the middle of a long run. Because the raw-mode check compares the output with the raw input in the same cycle, the bench samples the output only on falling edges, after the raw input has settled.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_state_e;
endpackage

// File: rtl/lock_err_cmp.sv
module lock_err_cmp #(
  parameter int ERR_W = 12
) (
  input  logic [ERR_W-1:0] err_i,
  input  logic [ERR_W-1:0] thr_i,
  output logic             below_o,
  output logic             above_o
);
  always_comb begin
    below_o = err_i < thr_i;
    above_o = err_i > thr_i;
  end
endmodule

// File: rtl/lock_run_cnt.sv
module lock_run_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // run completes when the counter already holds the limit (so it would exceed it)
  assign done_o = inc_i & (cnt_q >= limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || done_o) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/run_lock_detector.sv
module run_lock_detector
  import lock_det_pkg::*;
#(
  parameter int ERR_W     = 12,
  parameter int RUN_SEL_W = 2,
  parameter int BASE_LOG2 = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmp_valid_i,
  input  logic [ERR_W-1:0]     phase_err_i,
  input  logic [ERR_W-1:0]     thresh_i,
  input  logic [RUN_SEL_W-1:0] run_sel_i,
  input  logic                 raw_mode_i,
  input  logic                 pfd_raw_i,
  input  logic                 freq_set_i,
  output logic                 lock_o
);
  localparam int SEL_COUNT = 1 << RUN_SEL_W;
  localparam int MAX_RUN   = (1 << (BASE_LOG2 + SEL_COUNT - 1)) - 1;
  localparam int CNT_W     = $clog2(MAX_RUN + 2);

  lock_state_e      state_q;
  logic             lock_q;
  logic             err_below, err_above;
  logic             qualify, contrary, run_done;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] lim_tab [SEL_COUNT];

  for (genvar g = 0; g < SEL_COUNT; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((1 << (BASE_LOG2 + g)) - 1);
  end
  assign limit = lim_tab[run_sel_i];

  lock_err_cmp #(.ERR_W(ERR_W)) u_cmp (
    .err_i   (phase_err_i),
    .thr_i   (thresh_i),
    .below_o (err_below),
    .above_o (err_above)
  );

  assign lock_q   = (state_q == ST_LOCKED);
  assign qualify  = cmp_valid_i & (lock_q ? err_above : err_below);
  assign contrary = cmp_valid_i & ~qualify;

  lock_run_cnt #(.CNT_W(CNT_W)) u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (freq_set_i | contrary),
    .inc_i   (qualify & ~freq_set_i),
    .limit_i (limit),
    .cnt_o   (run_cnt),
    .done_o  (run_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNLOCKED;
    end else if (freq_set_i) begin
      state_q <= ST_UNLOCKED;
    end else if (run_done) begin
      state_q <= lock_q ? ST_UNLOCKED : ST_LOCKED;
    end
  end

  assign lock_o = raw_mode_i ? pfd_raw_i : lock_q;
endmodule

// File: rtl/run_lock_detector_chk.sv
module run_lock_detector_chk #(
  parameter int ERR_W   = 12,
  parameter int CNT_W   = 7,
  parameter int MAX_RUN = 63
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp_valid_i,
  input logic [ERR_W-1:0] phase_err_i,
  input logic [ERR_W-1:0] thresh_i,
  input logic             freq_set_i,
  input logic             raw_mode_i,
  input logic             pfd_raw_i,
  input logic             lock_o,
  input logic             lock_q,
  input logic [CNT_W-1:0] run_cnt
);
  AST_RESET_STATE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !lock_q && (run_cnt == '0));  // R1

  AST_LOCK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(cmp_valid_i) && !$past(freq_set_i)
                      && ($past(phase_err_i) < $past(thresh_i)));  // R2

  AST_UNLOCK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(freq_set_i)
                      || ($past(cmp_valid_i) && ($past(phase_err_i) > $past(thresh_i))));  // R4

  AST_FREQ_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_set_i |=> !lock_q && (run_cnt == '0));  // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i && !freq_set_i |=> $stable(lock_q) && $stable(run_cnt));  // R7

  AST_RAW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_mode_i |-> (lock_o == pfd_raw_i));  // R8

  AST_CLEAR_ON_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_q) |-> (run_cnt == '0));  // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CNT_W'(MAX_RUN));  // R10
endmodule

bind run_lock_detector run_lock_detector_chk #(
  .ERR_W   (ERR_W),
  .CNT_W   (CNT_W),
  .MAX_RUN (MAX_RUN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmp_valid_i (cmp_valid_i),
  .phase_err_i (phase_err_i),
  .thresh_i    (thresh_i),
  .freq_set_i  (freq_set_i),
  .raw_mode_i  (raw_mode_i),
  .pfd_raw_i   (pfd_raw_i),
  .lock_o      (lock_o),
  .lock_q      (lock_q),
  .run_cnt     (run_cnt)
);

// File: tb/run_lock_detector_test.sv
module run_lock_detector_test;
  localparam int ERR_W = 12;
  localparam logic [ERR_W-1:0] THR   = 12'd100;
  localparam logic [ERR_W-1:0] SMALL = 12'd10;
  localparam logic [ERR_W-1:0] EQUAL = 12'd100;
  localparam logic [ERR_W-1:0] LARGE = 12'd200;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmp_valid_i = 1'b0;
  logic [ERR_W-1:0] phase_err_i = '0;
  logic [ERR_W-1:0] thresh_i = THR;
  logic [1:0]       run_sel_i = 2'b00;
  logic             raw_mode_i = 1'b0;
  logic             pfd_raw_i = 1'b0;
  logic             freq_set_i = 1'b0;
  logic             lock_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  run_lock_detector #(.ERR_W(ERR_W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmp_valid_i (cmp_valid_i),
    .phase_err_i (phase_err_i),
    .thresh_i    (thresh_i),
    .run_sel_i   (run_sel_i),
    .raw_mode_i  (raw_mode_i),
    .pfd_raw_i   (pfd_raw_i),
    .freq_set_i  (freq_set_i),
    .lock_o      (lock_o)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (lock_o !== exp) begin
      errors++;
      $display("FAIL %s: lock_o=%b expected %b at %0t", req, lock_o, exp, $time);
    end
  endtask

  task automatic strobe(input logic [ERR_W-1:0] err);
    @(negedge clk);
    cmp_valid_i = 1'b1;
    phase_err_i = err;
    @(negedge clk);
    cmp_valid_i = 1'b0;
    phase_err_i = LARGE - err;  // junk on idle cycles
  endtask

  task automatic strobes(input logic [ERR_W-1:0] err, input int n);
    for (int i = 0; i < n; i++) strobe(err);
  endtask

  task automatic freq_pulse();
    @(negedge clk);
    freq_set_i = 1'b1;
    @(negedge clk);
    freq_set_i = 1'b0;
  endtask

  task automatic go_locked();
    run_sel_i = 2'b00;
    freq_pulse();
    strobes(SMALL, 8);
  endtask

  task automatic t_reset();
    check(1'b0, "R1 reset unlocked");
  endtask

  task automatic t_run_len();
    for (int s = 0; s < 4; s++) begin
      int n;
      n = (8 << s) - 1;
      run_sel_i = 2'(s);
      freq_pulse();
      strobes(SMALL, n);
      check(1'b0, $sformatf("R2 sel=%0d no lock after N", s));
      strobe(SMALL);
      check(1'b1, $sformatf("R2 sel=%0d lock after N+1", s));
    end
  endtask

  task automatic t_unlocked_clear();
    run_sel_i = 2'b00;
    freq_pulse();
    strobes(SMALL, 5);
    strobe(EQUAL);
    strobes(SMALL, 7);
    check(1'b0, "R3 equal error restarts run");
    strobe(SMALL);
    check(1'b1, "R3 lock after fresh run");
  endtask

  task automatic t_unlock_and_flip();
    go_locked();
    check(1'b1, "R9 locked");
    strobes(LARGE, 7);
    check(1'b1, "R9 counter cleared at lock");
    strobe(LARGE);
    check(1'b0, "R4 unlock after N+1 large");
  endtask

  task automatic t_locked_clear();
    go_locked();
    strobes(LARGE, 5);
    strobe(EQUAL);
    strobes(LARGE, 7);
    check(1'b1, "R5 equal error restarts large run");
    strobe(LARGE);
    check(1'b0, "R5 unlock after fresh run");
  endtask

  task automatic t_freq();
    go_locked();
    freq_pulse();
    check(1'b0, "R6 frequency change unlocks");
    strobes(SMALL, 7);
    @(negedge clk);
    cmp_valid_i = 1'b1;
    phase_err_i = SMALL;
    freq_set_i  = 1'b1;
    @(negedge clk);
    cmp_valid_i = 1'b0;
    freq_set_i  = 1'b0;
    check(1'b0, "R6 pulse beats same-cycle strobe");
    strobes(SMALL, 7);
    check(1'b0, "R6 counter cleared by pulse");
    strobe(SMALL);
    check(1'b1, "R6 lock after fresh run");
  endtask

  task automatic t_idle();
    go_locked();
    strobes(LARGE, 6);
    phase_err_i = SMALL;
    thresh_i = 12'd4000;
    repeat (20) @(negedge clk);
    thresh_i = THR;
    check(1'b1, "R7 idle cycles keep lock");
    strobe(LARGE);
    check(1'b1, "R7 run not disturbed (7 large)");
    strobe(LARGE);
    check(1'b0, "R7 run kept across idle");
  endtask

  task automatic t_raw();
    run_sel_i = 2'b00;
    freq_pulse();
    raw_mode_i = 1'b1;
    pfd_raw_i = 1'b1;
    #1 check(1'b1, "R8 raw high passes");
    pfd_raw_i = 1'b0;
    #1 check(1'b0, "R8 raw low passes");
    strobes(SMALL, 8);
    check(1'b0, "R8 output still raw");
    raw_mode_i = 1'b0;
    #1 check(1'b1, "R8 decision ran in background");
  endtask

  task automatic t_sel_lower();
    run_sel_i = 2'b11;
    freq_pulse();
    strobes(SMALL, 40);
    check(1'b0, "R10 long run not yet locked");
    run_sel_i = 2'b00;
    strobe(SMALL);
    check(1'b1, "R10 lowered select completes run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_len();
    t_unlocked_clear();
    t_unlock_and_flip();
    t_locked_clear();
    t_freq();
    t_idle();
    t_raw();
    t_sel_lower();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule